// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver with Standby

This block receives asynchronous serial characters on a single line. The line is sampled on a receiver-time tick that runs at sixteen times the bit rate. The receiver looks for a falling edge. It confirms the start bit at mid-bit, then takes three samples of every data bit and of the stop bit and decides each bit by majority vote. It delivers characters of either 8 or 9 data bits into a receive register, which has ready, framing-error, noise and overrun flags and a receive interrupt.

On a bus with several receivers, software can put the receiver into standby. In standby the receiver keeps decoding frames, but it delivers nothing and raises no interrupt until one of two events brings it back:

- an addressing character, whose most significant data bit is 1, arrives; or
- the line stays idle for a full character time.

A mode input selects which of these two events is used.

Top module: `rxo_receiver`

## Requirements
- R1: After synchronous reset, the following are all 0: `rx_data`, `rx_ready`, `frame_err`, `noise_err`, `overrun`, `rx_irq` and `standby`.
- R2: The receiver is hunting when it is not inside a frame. A tick whose sample is low, after a tick whose sample was high, is RT tick index 0 of a new frame. The start bit is confirmed only when the majority of the samples at tick indices 7, 8 and 9 is low. Otherwise the receiver returns to hunting and nothing is delivered.
- R3: Bit k of a frame spans tick indices 16k to 16k+15. Bit 0 is the start bit, data follows least significant bit first, and the stop bit comes last. Each bit's value is the majority of its samples at indices 16k+7, 16k+8 and 16k+9. If the three samples of any bit in a character disagree, that character is delivered with `noise_err`=1.
- R4: When `nine_bit`=0, a character has 8 data bits. They appear in `rx_data[7:0]` with `rx_data[8]`=0, and the stop decision is taken at tick index 153. When `nine_bit`=1, all 9 bits are delivered and the decision is at index 169. The outputs change on the clock edge of the tick on which the decision is taken.
- R5: A character sent by a transmitter whose bit time is 3.8% short (8-bit mode) or 3.4% short (9-bit mode) is received with the correct data and no framing error.
- R6: A low stop-bit vote delivers the character with `frame_err`=1. `frame_err` and `noise_err` always describe the most recently delivered character.
- R7: Delivery of a character sets `rx_ready`. A `rd_strobe` pulse clears `rx_ready` and `overrun`. If delivery and `rd_strobe` happen on the same clock, `rx_ready` ends up set.
- R8: If a character is delivered while `rx_ready` is already set, and there is no `rd_strobe` on that clock, `overrun` is set and `rx_data` takes the new character.
- R9: `rx_irq` is 1 exactly when `rx_ready` is 1 and `standby` is 0.
- R10: A `wake_set` pulse sets `standby` on the next clock edge. It takes priority over any hardware clear on the same edge.
- R11: With `wake_by_idle`=0, consider a character that completes while the receiver is in standby. If its most significant data bit is 1 (bit 7 in 8-bit mode, bit 8 in 9-bit mode), it clears `standby` and is delivered normally. Any other such character is discarded, and `rx_data` and every flag are left unchanged.
- R12: With `wake_by_idle`=1, every character that completes in standby is discarded. `standby` clears on the 160th consecutive hunting tick with a high line (176th in 9-bit mode). The count starts with the first tick after the edge that set `standby`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, synchronous to `clk`, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_by_idle | input | 1 | Standby exit: 1 = idle line, 0 = address character |
| wake_set | input | 1 | Pulse to enter standby |
| rd_strobe | input | 1 | Pulse that acknowledges the received character |
| rx_data | output | 9 | Last delivered character |
| rx_ready | output | 1 | A delivered character awaits reading |
| frame_err | output | 1 | Stop bit of the last character voted low |
| noise_err | output | 1 | Sample disagreement in the last character |
| overrun | output | 1 | A character arrived while `rx_ready` was set |
| rx_irq | output | 1 | Receive interrupt |
| standby | output | 1 | Receiver is in standby |

## Verification
The character results (data, flags, ready and, for an address character, the `standby` clear) are due on the clock edge of the tick at index 153 or 169 after RT tick 0. An idle wake is due on the clock edge of the tick that supplies the last high sample needed. `wake_set` and `rd_strobe` take effect on the edge directly after the cycle in which they are driven, and `rx_irq` follows in the same cycle. The bench's model advances by one rising edge each time the bench drives inputs. At the following falling edge every output is compared with the model, so each result is checked in exactly the cycle it is due and in every other cycle as well.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    localparam int DATA_MAX = 9;

    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_FRAME = 1'b1
    } fr_state_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                ferr;
        logic                noise;
    } rx_char_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return (a ^ b) | (b ^ c);
    endfunction

endpackage

// File: rtl/rxo_framer.sv
module rxo_framer
    import rxo_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     rt_tick,
    input  logic     rxd,
    input  logic     nine_bit,
    output logic     done,
    output rx_char_t chr,
    output logic     hunting
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] PH_A   = PW'(OVS/2 - 1);
    localparam logic [PW-1:0] PH_B   = PW'(OVS/2);
    localparam logic [PW-1:0] PH_C   = PW'(OVS/2 + 1);
    localparam logic [PW-1:0] PH_END = PW'(OVS - 1);

    fr_state_t           st;
    logic [PW-1:0]       ph;
    logic [3:0]          bidx;
    logic                s_a, s_b, prev_hi, noise_acc;
    logic [DATA_MAX-1:0] shreg;
    logic [3:0]          last_bit;
    logic                at_vote, vote, dis;

    always_comb begin
        last_bit  = nine_bit ? 4'd10 : 4'd9;
        at_vote   = rt_tick && (st == ST_FRAME) && (ph == PH_C);
        vote      = maj3(s_a, s_b, rxd);
        dis       = split3(s_a, s_b, rxd);
        done      = at_vote && (bidx == last_bit);
        chr.data  = nine_bit ? shreg : {1'b0, shreg[DATA_MAX-1:1]};
        chr.ferr  = ~vote;
        chr.noise = noise_acc | dis;
        hunting   = (st == ST_HUNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HUNT;
            ph        <= '0;
            bidx      <= '0;
            s_a       <= 1'b1;
            s_b       <= 1'b1;
            prev_hi   <= 1'b0;
            noise_acc <= 1'b0;
            shreg     <= '0;
        end else if (rt_tick) begin
            prev_hi <= rxd;
            if (st == ST_HUNT) begin
                if (prev_hi && !rxd) begin
                    st        <= ST_FRAME;
                    ph        <= PW'(1);
                    bidx      <= '0;
                    noise_acc <= 1'b0;
                end
            end else begin
                ph <= ph + 1'b1;
                if (ph == PH_END) bidx <= bidx + 1'b1;
                if (ph == PH_A) s_a <= rxd;
                if (ph == PH_B) s_b <= rxd;
                if (ph == PH_C) begin
                    noise_acc <= noise_acc | dis;
                    if (bidx == 4'd0) begin
                        if (vote) st <= ST_HUNT;
                    end else if (bidx == last_bit) begin
                        st <= ST_HUNT;
                    end else begin
                        shreg <= {vote, shreg[DATA_MAX-1:1]};
                    end
                end
            end
        end
    end

    // R2: a frame only begins on a tick that sampled the line low
    a_r2_start_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(hunting) |-> ($past(rt_tick) && !$past(rxd)));

endmodule

// File: rtl/rxo_wake.sv
module rxo_wake #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic rt_tick,
    input  logic rxd,
    input  logic hunting,
    input  logic nine_bit,
    input  logic wake_by_idle,
    input  logic wake_set,
    input  logic done,
    input  logic addr_bit,
    output logic standby,
    output logic deliver
);
    localparam int CW = $clog2(OVS * 11 + 1);

    logic [CW-1:0] cnt, lim;
    logic          counting, idle_hit, addr_wake;

    always_comb begin
        lim       = nine_bit ? CW'(OVS * 11) : CW'(OVS * 10);
        counting  = rt_tick && hunting && rxd;
        idle_hit  = standby && wake_by_idle && counting && (cnt == lim - 1'b1);
        addr_wake = standby && !wake_by_idle && done && addr_bit;
        deliver   = done && (!standby || addr_wake);
    end

    always_ff @(posedge clk) begin
        if (rst || !standby) begin
            cnt <= '0;
        end else if (rt_tick) begin
            if (counting) cnt <= (cnt == lim) ? cnt : cnt + 1'b1;
            else          cnt <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                        standby <= 1'b0;
        else if (wake_set)              standby <= 1'b1;
        else if (addr_wake || idle_hit) standby <= 1'b0;
    end

    // R10: software request enters standby on the next edge
    a_r10_enter: assert property (@(posedge clk) disable iff (rst)
        wake_set |=> standby);

    // R11: in address mode standby only ends with a completed character
    a_r11_exit_on_char: assert property (@(posedge clk) disable iff (rst)
        ($fell(standby) && !$past(wake_by_idle)) |-> $past(done));

endmodule

// File: rtl/rxo_status.sv
module rxo_status
    import rxo_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                deliver,
    input  rx_char_t            chr,
    input  logic                rd_strobe,
    input  logic                standby,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                frame_err,
    output logic                noise_err,
    output logic                overrun,
    output logic                rx_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            rx_ready  <= 1'b0;
            frame_err <= 1'b0;
            noise_err <= 1'b0;
            overrun   <= 1'b0;
        end else if (deliver) begin
            rx_data   <= chr.data;
            frame_err <= chr.ferr;
            noise_err <= chr.noise;
            rx_ready  <= 1'b1;
            overrun   <= (rx_ready | overrun) & ~rd_strobe;
        end else if (rd_strobe) begin
            rx_ready  <= 1'b0;
            overrun   <= 1'b0;
        end
    end

    assign rx_irq = rx_ready & ~standby;

    // R7: delivery raises ready
    a_r7_ready_set: assert property (@(posedge clk) disable iff (rst)
        deliver |=> rx_ready);

    // R7: a read without delivery drops ready and overrun
    a_r7_read_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !deliver) |=> (!rx_ready && !overrun));

    // R8: unread character replaced raises overrun
    a_r8_overrun: assert property (@(posedge clk) disable iff (rst)
        (deliver && rx_ready && !rd_strobe) |=> overrun);

endmodule

// File: rtl/rxo_receiver.sv
module rxo_receiver
    import rxo_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rt_tick,
    input  logic                rxd,
    input  logic                nine_bit,
    input  logic                wake_by_idle,
    input  logic                wake_set,
    input  logic                rd_strobe,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                frame_err,
    output logic                noise_err,
    output logic                overrun,
    output logic                rx_irq,
    output logic                standby
);
    rx_char_t chr;
    logic     done, hunting, deliver, addr_bit;

    assign addr_bit = nine_bit ? chr.data[8] : chr.data[7];

    rxo_framer #(.OVS(OVS)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .rt_tick (rt_tick),
        .rxd     (rxd),
        .nine_bit(nine_bit),
        .done    (done),
        .chr     (chr),
        .hunting (hunting)
    );

    rxo_wake #(.OVS(OVS)) u_wake (
        .clk         (clk),
        .rst         (rst),
        .rt_tick     (rt_tick),
        .rxd         (rxd),
        .hunting     (hunting),
        .nine_bit    (nine_bit),
        .wake_by_idle(wake_by_idle),
        .wake_set    (wake_set),
        .done        (done),
        .addr_bit    (addr_bit),
        .standby     (standby),
        .deliver     (deliver)
    );

    rxo_status u_status (
        .clk      (clk),
        .rst      (rst),
        .deliver  (deliver),
        .chr      (chr),
        .rd_strobe(rd_strobe),
        .standby  (standby),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .frame_err(frame_err),
        .noise_err(noise_err),
        .overrun  (overrun),
        .rx_irq   (rx_irq)
    );

    // R11: a character dropped in standby leaves the register untouched
    a_r11_discard: assert property (@(posedge clk) disable iff (rst)
        (done && standby && !deliver && !rd_strobe) |=> ($stable(rx_data) && $stable(rx_ready)));

endmodule

// File: tb/sim_rxo_receiver.sv
module sim_rxo_receiver;
    logic clk = 1'b0, rst = 1'b1, rt_tick = 1'b0, rxd = 1'b1;
    logic nine_bit = 1'b0, wake_by_idle = 1'b0, wake_set = 1'b0, rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic rx_ready, frame_err, noise_err, overrun, rx_irq, standby;

    always #10 clk = ~clk;

    rxo_receiver u0 (
        .clk(clk), .rst(rst), .rt_tick(rt_tick), .rxd(rxd), .nine_bit(nine_bit),
        .wake_by_idle(wake_by_idle), .wake_set(wake_set), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_ready(rx_ready), .frame_err(frame_err),
        .noise_err(noise_err), .overrun(overrun), .rx_irq(rx_irq), .standby(standby)
    );

    int checks = 0, failures = 0;
    string cur_req = "R1";
    logic [8:0] e_data = '0;
    bit e_ready = 0, e_fe = 0, e_nz = 0, e_ovr = 0, e_stby = 0;
    int e_icnt = 0;
    bit ws_req = 0, rd_req = 0, ev_done = 0, in_frame = 0, ev_fe = 0, ev_nz = 0;
    logic [8:0] ev_data = '0;

    task automatic cmp(string name, logic [8:0] act, logic [8:0] exp);
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, name, act, exp, $time);
        end
    endtask

    task automatic check_all();
        checks++;
        cmp("rx_data", rx_data, e_data);
        cmp("rx_ready", {8'd0, rx_ready}, {8'd0, e_ready});
        cmp("frame_err", {8'd0, frame_err}, {8'd0, e_fe});
        cmp("noise_err", {8'd0, noise_err}, {8'd0, e_nz});
        cmp("overrun", {8'd0, overrun}, {8'd0, e_ovr});
        cmp("rx_irq", {8'd0, rx_irq}, {8'd0, e_ready && !e_stby});
        cmp("standby", {8'd0, standby}, {8'd0, e_stby});
    endtask

    // reference model: state after the coming rising edge
    task automatic model(bit tk, bit ln);
        bit addr, deliver, awake, ihit;
        int lim, ncnt;
        addr    = nine_bit ? ev_data[8] : ev_data[7];
        awake   = ev_done && e_stby && !wake_by_idle && addr;
        deliver = ev_done && (!e_stby || awake);
        lim     = nine_bit ? 176 : 160;
        ihit    = 0;
        ncnt    = e_icnt;
        if (!e_stby) ncnt = 0;
        else if (tk) begin
            if (!in_frame && ln) begin
                ncnt = (e_icnt >= lim) ? lim : e_icnt + 1;
                if (wake_by_idle && e_icnt == lim - 1) ihit = 1;
            end else ncnt = 0;
        end
        if (deliver) begin
            e_ovr   = (e_ready || e_ovr) && !rd_req;
            e_data  = ev_data;
            e_fe    = ev_fe;
            e_nz    = ev_nz;
            e_ready = 1;
        end else if (rd_req) begin
            e_ready = 0;
            e_ovr   = 0;
        end
        if (ws_req) e_stby = 1;
        else if (awake || ihit) e_stby = 0;
        e_icnt = ncnt;
    endtask

    task automatic step(bit tk, bit ln);
        @(negedge clk);
        check_all();
        rt_tick = tk; rxd = ln; wake_set = ws_req; rd_strobe = rd_req;
        model(tk, ln);
        ws_req = 0; rd_req = 0; ev_done = 0;
    endtask

    task automatic tick(bit ln);
        step(0, ln);
        step(1, ln);
    endtask

    task automatic idle(int n);
        in_frame = 0;
        repeat (n) tick(1);
    endtask

    task automatic pulse_rd();  rd_req = 1; step(0, 1); endtask
    task automatic pulse_ws();  ws_req = 1; step(0, 1); endtask

    function automatic bit lvl(int t, logic [8:0] d, int nb, bit sv, int bl, int flip_t);
        int k;
        bit v;
        k = (t * 100) / bl;
        if (k == 0) v = 0;
        else if (k <= nb) v = d[k-1];
        else v = sv;
        return v ^ (t == flip_t);
    endfunction

    // bl: transmitter bit time in hundredths of an RT tick
    task automatic send(logic [8:0] d, int nb, bit sv, int bl, int flip_t, int idle_after);
        int last;
        bit a, b, c, v, nz, fe;
        logic [8:0] got;
        last = (nb + 1) * 16 + 9;
        nz = 0; fe = 0; got = '0;
        for (int k = 0; k <= nb + 1; k++) begin
            a = lvl(16*k + 7, d, nb, sv, bl, flip_t);
            b = lvl(16*k + 8, d, nb, sv, bl, flip_t);
            c = lvl(16*k + 9, d, nb, sv, bl, flip_t);
            v = (a & b) | (a & c) | (b & c);
            if (!(a == b && b == c)) nz = 1;
            if (k >= 1 && k <= nb) got[k-1] = v;
            if (k == nb + 1) fe = !v;
        end
        for (int t = 0; t <= last; t++) begin
            step(0, lvl(t, d, nb, sv, bl, flip_t));
            in_frame = (t >= 1);
            if (t == last) begin
                ev_done = 1; ev_data = got; ev_fe = fe; ev_nz = nz;
            end
            step(1, lvl(t, d, nb, sv, bl, flip_t));
        end
        idle(idle_after);
    endtask

    task automatic glitch(int lowticks);
        for (int t = 0; t <= 9; t++) begin
            step(0, t >= lowticks);
            in_frame = (t >= 1);
            step(1, t >= lowticks);
        end
        idle(4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";  idle(3);
        cur_req = "R4";  send(9'h0A5, 8, 1, 1600, -1, 3);
        cur_req = "R7";  pulse_rd(); idle(1);
        cur_req = "R8";  send(9'h03C, 8, 1, 1600, -1, 2);
        send(9'h05A, 8, 1, 1600, -1, 2);
        cur_req = "R7";  pulse_rd(); idle(1);
        cur_req = "R6";  send(9'h081, 8, 0, 1600, -1, 3); pulse_rd();
        cur_req = "R3";  send(9'h04D, 8, 1, 1600, 56, 3); pulse_rd();
        cur_req = "R2";  glitch(3); glitch(6); idle(2);
        cur_req = "R5";  send(9'h0C3, 8, 1, 1539, -1, 2); pulse_rd();
        send(9'h0E7, 8, 1, 1660, -1, 2); pulse_rd();
        nine_bit = 1'b1; idle(1);
        cur_req = "R4";  send(9'h1A5, 9, 1, 1600, -1, 2); pulse_rd();
        cur_req = "R5";  send(9'h0F3, 9, 1, 1546, -1, 2); pulse_rd();
        nine_bit = 1'b0; idle(1);
        cur_req = "R9";  send(9'h011, 8, 1, 1600, -1, 2);
        cur_req = "R10"; pulse_ws(); idle(2);
        cur_req = "R11"; send(9'h022, 8, 1, 1600, -1, 2);
        send(9'h0A2, 8, 1, 1600, -1, 2); pulse_rd();
        nine_bit = 1'b1; idle(1);
        pulse_ws(); send(9'h0FF, 9, 1, 1600, -1, 2);
        send(9'h101, 9, 1, 1600, -1, 2); pulse_rd();
        nine_bit = 1'b0; wake_by_idle = 1'b1; idle(1);
        cur_req = "R12"; pulse_ws(); idle(2);
        send(9'h080, 8, 1, 1600, -1, 200);
        nine_bit = 1'b1; idle(1);
        pulse_ws(); idle(200);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL %s watchdog expired actual=running expected=finished", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule